// File: doc/BRIEF.md
# Three-Level SVM Segment Sequencer (Sector 1, Regions 2 and 3)

This block runs the switching period of a three-phase, three-level T-type inverter while the reference vector lies in regions 2 and 3 of the first sector. Each period has five segments laid out symmetrically. For each segment the block puts out one ternary state for each of the three phases, along with the index of that segment. It chooses the redundant small vectors with a hysteresis comparator on the neutral-point voltage error. When a loss-reduced scheme is selected, it also leaves out one of the outer small vectors, choosing by sub-region or by the sign of the phase-b current. This keeps the clamping-leg switch of phase b from being hard-switched.

All inputs are sampled once, at a period boundary. These are the region code, the sub-region flag, the phase-b current sign, the neutral-point error, the hysteresis band, three dwell counts and the scheme code. The sampled values then hold until the next boundary. A segment whose dwell is zero is dropped from the period. When the last segment ends, the next period starts immediately. Dwell times, sector and region detection, other sectors, and dead-time insertion are computed elsewhere.

Top module: `svm3l_seq_top`

## Requirements
- R1: While `rst` is high, `seg_o` is 0 and all three phase outputs are 2'b00.
- R2: A phase state is coded as 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The code 2'b10 never appears. The vectors are given as (a,b,c): V1=(0,-1,-1), V2=(0,0,-1), V3=(1,0,-1), V4=(1,0,0), V5=(1,1,0), V6=(1,-1,-1).
- R3: When the region code is anything other than 3 (region 2), every scheme uses the order V1,V6,V3,V6,V1 if the neutral point is high, and V6,V3,V4,V3,V6 if it is low.
- R4: In region 3, scheme 0 (basic) uses V3,V2,V1,V2,V3 if the neutral point is high, and V3,V4,V5,V4,V3 if it is low.
- R5: In region 3, scheme 1 (loss-reduced) with `subreg_i`=0 uses V1,V2,V3,V2,V1 (high) or V2,V3,V4,V3,V2 (low). With `subreg_i`=1 it uses V4,V3,V2,V3,V4 (high) or V5,V4,V3,V4,V5 (low).
- R6: In region 3, scheme 2 (current-based) ignores `subreg_i`. It takes the `subreg_i`=0 orders of R5 when `ib_neg_i`=1 and the `subreg_i`=1 orders when `ib_neg_i`=0.
- R7: Scheme code 3 behaves exactly like scheme 0.
- R8: At a period boundary, the neutral point becomes high if the signed `np_err_i` exceeds `band_i`. It becomes low if `np_err_i` is below -`band_i`. Otherwise, including the case where the error equals ±band, it keeps its previous value. After reset it is low.
- R9: Inputs are sampled only at a period boundary. Changes to any input during a period have no effect on that period's outputs.
- R10: Segments 0 to 4 last `dwell1_i`, `dwell2_i`, `dwell3_i`, `dwell2_i` and `dwell1_i` clock ticks. A segment with zero dwell is skipped. The next period begins on the tick after the last segment. The first period begins on the first clock edge after reset is released.
- R11: If all three dwells are zero, the period is a single tick showing segment 2 with its centre vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_i | input | 2 | Region code; 3 selects region 3, any other value region 2 |
| subreg_i | input | 1 | Region-3 sub-region: 0 for 3.1, 1 for 3.2 |
| ib_neg_i | input | 1 | Phase-b current is negative |
| np_err_i | input | EW | Signed neutral-point voltage minus half DC link |
| band_i | input | EW | Unsigned hysteresis half-band |
| dwell1_i | input | DW | Dwell of outer segments, in ticks |
| dwell2_i | input | DW | Dwell of middle segments, in ticks |
| dwell3_i | input | DW | Dwell of centre segment, in ticks |
| scheme_i | input | 2 | 0 basic, 1 loss-reduced, 2 current-based, 3 as basic |
| pha_o | output | 2 | Phase a state |
| phb_o | output | 2 | Phase b state |
| phc_o | output | 2 | Phase c state |
| seg_o | output | 3 | Current segment index 0..4 |

## Verification
The directed periods cover region 2 under all three schemes, the basic region-3 order, both sub-regions of the loss-reduced scheme, and the current-based scheme with the sub-region flag set against the current sign, which shows that the flag is ignored. Errors placed exactly on ±band and inside the band confirm that the neutral-point decision is held, while errors just past the band confirm that it flips. Dwell patterns with zeros in the outer, middle or all positions exercise segment skipping and the one-tick degenerate period. On every tick except the last, inputs are rewritten with random values, so any leak of a mid-period input into the outputs is caught. Random periods then mix all of these with a fixed seed.

// File: rtl/svm3l_pkg.sv
package svm3l_pkg;

    typedef logic [1:0] ph_t;
    localparam ph_t PH_POS  = 2'b01;
    localparam ph_t PH_ZERO = 2'b00;
    localparam ph_t PH_NEG  = 2'b11;

    typedef struct packed {
        ph_t a;
        ph_t b;
        ph_t c;
    } vec_t;

    typedef enum logic [2:0] {
        VID_Z = 3'd0,
        VID_1 = 3'd1,
        VID_2 = 3'd2,
        VID_3 = 3'd3,
        VID_4 = 3'd4,
        VID_5 = 3'd5,
        VID_6 = 3'd6
    } vid_e;

    typedef enum logic [1:0] {
        SCH_BASIC   = 2'd0,
        SCH_LOWLOSS = 2'd1,
        SCH_CURDIR  = 2'd2,
        SCH_SPARE   = 2'd3
    } scheme_e;

    // outer vector for segments 0/4, mid for 1/3, centre for 2
    typedef struct packed {
        vid_e outer;
        vid_e mid;
        vid_e ctr;
    } trip_t;

    localparam int NSEG = 5;

    function automatic vec_t vid_vec(vid_e v);
        vec_t r;
        case (v)
            VID_1:   r = '{a: PH_ZERO, b: PH_NEG,  c: PH_NEG};
            VID_2:   r = '{a: PH_ZERO, b: PH_ZERO, c: PH_NEG};
            VID_3:   r = '{a: PH_POS,  b: PH_ZERO, c: PH_NEG};
            VID_4:   r = '{a: PH_POS,  b: PH_ZERO, c: PH_ZERO};
            VID_5:   r = '{a: PH_POS,  b: PH_POS,  c: PH_ZERO};
            VID_6:   r = '{a: PH_POS,  b: PH_NEG,  c: PH_NEG};
            default: r = '{a: PH_ZERO, b: PH_ZERO, c: PH_ZERO};
        endcase
        return r;
    endfunction

    function automatic trip_t mk_trip(vid_e o, vid_e m, vid_e c);
        trip_t t;
        t.outer = o;
        t.mid   = m;
        t.ctr   = c;
        return t;
    endfunction

    function automatic vid_e seg_vid(trip_t t, logic [2:0] s);
        vid_e v;
        case (s)
            3'd0, 3'd4: v = t.outer;
            3'd1, 3'd3: v = t.mid;
            default:    v = t.ctr;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/np_hyst.sv
module np_hyst #(
    parameter int EW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_i,
    input  logic [EW-1:0] err_i,
    input  logic [EW-1:0] band_i,
    output logic          hi_next_o,
    output logic          hi_q_o
);
    localparam int XW = EW + 2;

    logic signed [XW-1:0] err_x;
    logic signed [XW-1:0] band_x;
    logic                 above;
    logic                 below;
    logic                 hi_q;

    always_comb begin
        err_x     = {{2{err_i[EW-1]}}, err_i};
        band_x    = {2'b00, band_i};
        above     = err_x > band_x;
        below     = err_x < -band_x;
        hi_next_o = above ? 1'b1 : (below ? 1'b0 : hi_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
        end else if (upd_i) begin
            hi_q <= hi_next_o;
        end
    end

    assign hi_q_o = hi_q;

    // R8
    np_set_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (err_x > band_x)) |=> hi_q);

    // R8
    np_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (err_x < -band_x)) |=> !hi_q);

    // R9
    np_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(hi_q));

endmodule

// File: rtl/seq_chooser.sv
module seq_chooser
    import svm3l_pkg::*;
(
    input  logic    reg3_i,
    input  logic    sub32_i,
    input  logic    ib_neg_i,
    input  logic    np_hi_i,
    input  scheme_e sch_i,
    output trip_t   trip_o
);
    logic side32;

    always_comb begin
        side32 = (sch_i == SCH_CURDIR) ? !ib_neg_i : sub32_i;
        if (!reg3_i) begin
            trip_o = np_hi_i ? mk_trip(VID_1, VID_6, VID_3)
                             : mk_trip(VID_6, VID_3, VID_4);
        end else if (sch_i == SCH_LOWLOSS || sch_i == SCH_CURDIR) begin
            if (!side32)
                trip_o = np_hi_i ? mk_trip(VID_1, VID_2, VID_3)
                                 : mk_trip(VID_2, VID_3, VID_4);
            else
                trip_o = np_hi_i ? mk_trip(VID_4, VID_3, VID_2)
                                 : mk_trip(VID_5, VID_4, VID_3);
        end else begin
            trip_o = np_hi_i ? mk_trip(VID_3, VID_2, VID_1)
                             : mk_trip(VID_3, VID_4, VID_5);
        end
    end

endmodule

// File: rtl/seg_timer.sv
module seg_timer
    import svm3l_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d1_i,
    input  logic [DW-1:0] d2_i,
    input  logic [DW-1:0] d3_i,
    output logic          load_o,
    output logic [2:0]    seg_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic          run_q;
    logic [2:0]    seg_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] c1_q, c2_q, c3_q;
    logic [2:0]    nxt, first;
    logic          last, allz;
    logic [DW-1:0] first_dur, nxt_dur;

    function automatic logic [DW-1:0] dur_of(logic [2:0] s, logic [DW-1:0] a,
                                             logic [DW-1:0] b, logic [DW-1:0] c);
        logic [DW-1:0] r;
        case (s)
            3'd0, 3'd4: r = a;
            3'd1, 3'd3: r = b;
            default:    r = c;
        endcase
        return r;
    endfunction

    always_comb begin
        last = 1'b1;
        nxt  = seg_q;
        for (int k = NSEG - 1; k >= 0; k--) begin
            if (3'(k) > seg_q && dur_of(3'(k), c1_q, c2_q, c3_q) != '0) begin
                nxt  = 3'(k);
                last = 1'b0;
            end
        end
        nxt_dur = dur_of(nxt, c1_q, c2_q, c3_q);

        allz  = (d1_i == '0) && (d2_i == '0) && (d3_i == '0);
        first = 3'd2;
        for (int k = NSEG - 1; k >= 0; k--) begin
            if (dur_of(3'(k), d1_i, d2_i, d3_i) != '0)
                first = 3'(k);
        end
        first_dur = allz ? ONE : dur_of(first, d1_i, d2_i, d3_i);

        load_o = !run_q || (cnt_q == ONE && last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            seg_q <= 3'd0;
            cnt_q <= '0;
            c1_q  <= '0;
            c2_q  <= '0;
            c3_q  <= '0;
        end else if (load_o) begin
            run_q <= 1'b1;
            seg_q <= first;
            cnt_q <= first_dur;
            c1_q  <= d1_i;
            c2_q  <= d2_i;
            c3_q  <= d3_i;
        end else if (cnt_q == ONE) begin
            seg_q <= nxt;
            cnt_q <= nxt_dur;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign seg_o = seg_q;

    // R10
    seg_range_chk: assert property (@(posedge clk) disable iff (rst)
        seg_q <= 3'd4);

    // R10
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != ONE) |=> $stable(seg_q));

    // R11
    all_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (load_o && allz) |=> (seg_q == 3'd2 && cnt_q == ONE));

endmodule

// File: rtl/svm3l_seq_top.sv
module svm3l_seq_top
    import svm3l_pkg::*;
#(
    parameter int DW = 8,
    parameter int EW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    region_i,
    input  logic          subreg_i,
    input  logic          ib_neg_i,
    input  logic [EW-1:0] np_err_i,
    input  logic [EW-1:0] band_i,
    input  logic [DW-1:0] dwell1_i,
    input  logic [DW-1:0] dwell2_i,
    input  logic [DW-1:0] dwell3_i,
    input  logic [1:0]    scheme_i,
    output logic [1:0]    pha_o,
    output logic [1:0]    phb_o,
    output logic [1:0]    phc_o,
    output logic [2:0]    seg_o
);
    logic  load;
    logic  np_hi_next;
    logic  np_hi_q;
    logic  [2:0] seg;
    trip_t trip_new;
    trip_t trip_q;
    vec_t  vec;

    seg_timer #(.DW(DW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .d1_i   (dwell1_i),
        .d2_i   (dwell2_i),
        .d3_i   (dwell3_i),
        .load_o (load),
        .seg_o  (seg)
    );

    np_hyst #(.EW(EW)) u_hyst (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (load),
        .err_i     (np_err_i),
        .band_i    (band_i),
        .hi_next_o (np_hi_next),
        .hi_q_o    (np_hi_q)
    );

    seq_chooser u_choose (
        .reg3_i   (region_i == 2'd3),
        .sub32_i  (subreg_i),
        .ib_neg_i (ib_neg_i),
        .np_hi_i  (np_hi_next),
        .sch_i    (scheme_e'(scheme_i)),
        .trip_o   (trip_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= mk_trip(VID_Z, VID_Z, VID_Z);
        end else if (load) begin
            trip_q <= trip_new;
        end
    end

    always_comb begin
        vec   = vid_vec(seg_vid(trip_q, seg));
        pha_o = vec.a;
        phb_o = vec.b;
        phc_o = vec.c;
        seg_o = seg;
    end

    // R2
    ph_code_chk: assert property (@(posedge clk) disable iff (rst)
        pha_o != 2'b10 && phb_o != 2'b10 && phc_o != 2'b10);

    // R9
    seq_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(trip_q));

    // R1
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_zero_chk: assert (np_hi_q == 1'b0 || !load);
        end
    end

endmodule

// File: tb/sim_svm3l_seq_top.sv
`timescale 1ns/1ps
module sim_svm3l_seq_top;
    localparam int DW = 8;
    localparam int EW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    region_i = '0;
    logic          subreg_i = 1'b0;
    logic          ib_neg_i = 1'b0;
    logic [EW-1:0] np_err_i = '0;
    logic [EW-1:0] band_i = '0;
    logic [DW-1:0] dwell1_i = '0;
    logic [DW-1:0] dwell2_i = '0;
    logic [DW-1:0] dwell3_i = '0;
    logic [1:0]    scheme_i = '0;
    logic [1:0]    pha_o, phb_o, phc_o;
    logic [2:0]    seg_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit hi_m = 1'b0;

    typedef struct {
        int region; bit sub; bit ineg; int err; int band;
        int d1; int d2; int d3; int sch;
    } prm_t;

    prm_t plist[$];

    svm3l_seq_top #(.DW(DW), .EW(EW)) u0 (
        .clk(clk), .rst(rst), .region_i(region_i), .subreg_i(subreg_i),
        .ib_neg_i(ib_neg_i), .np_err_i(np_err_i), .band_i(band_i),
        .dwell1_i(dwell1_i), .dwell2_i(dwell2_i), .dwell3_i(dwell3_i),
        .scheme_i(scheme_i), .pha_o(pha_o), .phb_o(phb_o), .phc_o(phc_o),
        .seg_o(seg_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc == 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // R2: +1 -> 01, 0 -> 00, -1 -> 11, packed as {a,b,c}
    function automatic logic [5:0] bvec(int id);
        case (id)
            1: return 6'b00_11_11;
            2: return 6'b00_00_11;
            3: return 6'b01_00_11;
            4: return 6'b01_00_00;
            5: return 6'b01_01_00;
            6: return 6'b01_11_11;
            default: return 6'b00_00_00;
        endcase
    endfunction

    task automatic exp_ids(prm_t p, bit hi, output int o, output int m, output int c);
        bit side;
        if (p.region != 3) begin
            if (hi) begin o = 1; m = 6; c = 3; end
            else    begin o = 6; m = 3; c = 4; end
        end else if (p.sch == 1 || p.sch == 2) begin
            side = (p.sch == 2) ? !p.ineg : p.sub;
            if (!side) begin
                if (hi) begin o = 1; m = 2; c = 3; end
                else    begin o = 2; m = 3; c = 4; end
            end else begin
                if (hi) begin o = 4; m = 3; c = 2; end
                else    begin o = 5; m = 4; c = 3; end
            end
        end else begin
            if (hi) begin o = 3; m = 2; c = 1; end
            else    begin o = 3; m = 4; c = 5; end
        end
    endtask

    task automatic check(bit ok, string tag, string what, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic drive(prm_t p);
        region_i = 2'(p.region);
        subreg_i = p.sub;
        ib_neg_i = p.ineg;
        np_err_i = EW'(p.err);
        band_i   = EW'(p.band);
        dwell1_i = DW'(p.d1);
        dwell2_i = DW'(p.d2);
        dwell3_i = DW'(p.d3);
        scheme_i = 2'(p.sch);
    endtask

    task automatic scramble();
        region_i = 2'($urandom);
        subreg_i = 1'($urandom);
        ib_neg_i = 1'($urandom);
        np_err_i = EW'($urandom);
        band_i   = EW'($urandom);
        dwell1_i = DW'($urandom);
        dwell2_i = DW'($urandom);
        dwell3_i = DW'($urandom);
        scheme_i = 2'($urandom);
    endtask

    task automatic run_period(prm_t cur, prm_t nxt);
        int o, m, c, total, t;
        int dur[5];
        int ids[5];
        bit inband, allz;
        string tag;
        inband = 1'b0;
        if (cur.err > cur.band) hi_m = 1'b1;
        else if (cur.err < -cur.band) hi_m = 1'b0;
        else inband = 1'b1;
        exp_ids(cur, hi_m, o, m, c);
        ids = '{o, m, c, m, o};
        dur = '{cur.d1, cur.d2, cur.d3, cur.d2, cur.d1};
        allz = (cur.d1 == 0 && cur.d2 == 0 && cur.d3 == 0);
        if (allz) dur[2] = 1;
        if (allz) tag = "R11";
        else if (inband) tag = "R8";
        else if (cur.region != 3) tag = "R3";
        else if (cur.sch == 1) tag = "R5";
        else if (cur.sch == 2) tag = "R6";
        else if (cur.sch == 3) tag = "R7";
        else tag = "R4";
        total = 0;
        foreach (dur[i]) total += dur[i];
        t = 0;
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < dur[s]; k++) begin
                @(negedge clk);
                check(seg_o == 3'(s), "R10", "segment index", int'(seg_o), s);
                check({pha_o, phb_o, phc_o} == bvec(ids[s]), (t == 0) ? tag : "R9",
                      "phase states", int'({pha_o, phb_o, phc_o}), int'(bvec(ids[s])));
                check(pha_o != 2'b10 && phb_o != 2'b10 && phc_o != 2'b10, "R2",
                      "illegal code", int'({pha_o, phb_o, phc_o}), 0);
                t++;
                if (t == total) drive(nxt);
                else scramble();
            end
        end
    endtask

    function automatic prm_t mkp(int region, bit sub, bit ineg, int err, int band,
                                 int d1, int d2, int d3, int sch);
        prm_t p;
        p.region = region; p.sub = sub; p.ineg = ineg; p.err = err; p.band = band;
        p.d1 = d1; p.d2 = d2; p.d3 = d3; p.sch = sch;
        return p;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        plist.push_back(mkp(2, 0, 0, -10, 5, 3, 2, 4, 0)); // R3 low
        plist.push_back(mkp(2, 1, 0,  10, 5, 1, 1, 1, 1)); // R3 high
        plist.push_back(mkp(0, 0, 1,   2, 5, 2, 1, 2, 2)); // R8 hold high
        plist.push_back(mkp(3, 0, 0,  20, 5, 2, 0, 3, 0)); // R4 high, mid skipped
        plist.push_back(mkp(3, 0, 0, -20, 5, 0, 2, 2, 0)); // R4 low, outer skipped
        plist.push_back(mkp(3, 0, 0,  20, 5, 1, 2, 3, 1)); // R5 3.1 high
        plist.push_back(mkp(3, 0, 0, -20, 5, 2, 2, 1, 1)); // R5 3.1 low
        plist.push_back(mkp(3, 1, 0,  -5, 5, 1, 3, 1, 1)); // R8 edge hold low
        plist.push_back(mkp(3, 1, 0,   6, 5, 2, 1, 2, 1)); // R5 3.2 high
        plist.push_back(mkp(3, 1, 1,  30, 3, 1, 1, 2, 2)); // R6 neg, sub ignored
        plist.push_back(mkp(3, 0, 0, -30, 3, 2, 1, 1, 2)); // R6 pos low
        plist.push_back(mkp(3, 0, 0,  30, 3, 1, 2, 1, 2)); // R6 pos high
        plist.push_back(mkp(3, 1, 1,  30, 3, 2, 2, 2, 3)); // R7
        plist.push_back(mkp(3, 0, 0,   0, 3, 0, 0, 0, 1)); // R11
        plist.push_back(mkp(2, 0, 0, -40, 3, 0, 0, 0, 0)); // R11 again, low
        plist.push_back(mkp(3, 0, 1, -40, 3, 0, 0, 5, 0)); // R10 centre only
        plist.push_back(mkp(3, 1, 0,  40, 0, 7, 0, 0, 1)); // R10 outer only
        for (int i = 0; i < 200; i++) begin
            plist.push_back(mkp(int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                                int'($urandom_range(0, 80)) - 40, int'($urandom_range(0, 20)),
                                int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                                int'($urandom_range(0, 5)), int'($urandom_range(0, 3))));
        end
        plist.push_back(mkp(2, 0, 0, 0, 0, 1, 1, 1, 0));

        drive(plist[0]);
        repeat (3) @(negedge clk);
        // R1
        check(seg_o == 3'd0, "R1", "reset segment", int'(seg_o), 0);
        check({pha_o, phb_o, phc_o} == 6'd0, "R1", "reset phases",
              int'({pha_o, phb_o, phc_o}), 0);
        rst = 1'b0;
        for (int i = 0; i + 1 < plist.size(); i++) begin
            run_period(plist[i], plist[i + 1]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule